// File: doc/BRIEF.md
# Microframe Periodic Window Scheduler

This block times each bus frame or microframe and places two programmable marks inside it. The first mark is an end-of-periodic-frame interrupt: a one-cycle pulse that tells software to check whether the isochronous traffic for the current interval has finished. The second mark ends a window at the start of the interval. During that window a DMA fetch engine is granted to periodic IN endpoint data. After the window, the engine serves non-periodic endpoints.

A start-of-frame strobe restarts an internal cycle counter. On that strobe the block samples the interval length in clocks and both 2-bit selection codes. From these it computes both thresholds as truncated integer fractions of the interval length. A live flag reports whether any periodic endpoint is active. While that flag is low, the periodic window is skipped and non-periodic endpoints hold the grant.

Top module: `periodic_window_sched`

## Requirements
- R1: After reset and before the first start-of-frame strobe, `eopf_irq_o` and `per_grant_o` are both 0.
- R2: A start-of-frame strobe sampled on a rising edge sets the interval counter to 0 for the following cycle. The counter then advances by one per cycle, with t = 0 being the cycle just after that edge.
- R3: `int_pt_i` codes 0, 1, 2 and 3 select 80, 85, 90 and 95 percent. The interrupt pulses in cycle t = floor(len * pct / 100).
- R4: The interrupt is high for exactly one cycle and fires at most once per interval.
- R5: If the next start-of-frame strobe arrives before the interrupt threshold is reached, no interrupt is issued for that interval.
- R6: `win_sel_i` codes 2'b00, 2'b01 and 2'b10 select 25, 50 and 75 percent. While `per_active_i` is 1, `per_grant_o` is 1 for t < floor(len * pct / 100) and 0 for the rest of the interval.
- R7: The reserved `win_sel_i` code 2'b11 behaves as 2'b00, giving a 25 percent window.
- R8: While `per_active_i` is 0, `per_grant_o` is 0 whatever `win_sel_i` holds.
- R9: `int_pt_i` and `win_sel_i` are sampled only on start-of-frame strobes. A change in the middle of an interval does not move that interval's marks.
- R10: `frame_len_i` is sampled only on start-of-frame strobes. A change in the middle of an interval does not move that interval's marks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sof_i | input | 1 | Start-of-frame strobe, one cycle |
| frame_len_i | input | LEN_W | Interval length in clock cycles |
| int_pt_i | input | 2 | Interrupt point code (80/85/90/95 percent) |
| win_sel_i | input | 2 | Periodic window code (25/50/75 percent, 11 as 00) |
| per_active_i | input | 1 | Any periodic endpoint active |
| eopf_irq_o | output | 1 | End-of-periodic-frame interrupt pulse |
| per_grant_o | output | 1 | 1: DMA fetches periodic data, 0: non-periodic |

## Verification
The main function is exercised with a table of intervals. The table covers every interrupt code and every window code, including the reserved one. It also varies the interval length: 100 cycles gives exact percentages, 7 and 1000 exercise truncation and a wide counter, and 40 and 200 give other round values. Each row is checked for the position of the interrupt, the number of pulses and the grant in every cycle, so an off-by-one threshold, a wrong percentage or a window that does not end cleanly shows up. One row holds the periodic flag low, which separates the bypass path from the windowed path. Directed runs then cover the idle state after reset, an interval cut short before its interrupt point, and mid-interval changes to the codes and to the length.

// File: rtl/pws_pkg.sv
package pws_pkg;
  function automatic logic [6:0] irq_pct(input logic [1:0] code);
    case (code)
      2'd0:    return 7'd80;
      2'd1:    return 7'd85;
      2'd2:    return 7'd90;
      default: return 7'd95;
    endcase
  endfunction

  // reserved code 2'b11 folds onto the 25% window
  function automatic logic [6:0] win_pct(input logic [1:0] code);
    case (code)
      2'b01:   return 7'd50;
      2'b10:   return 7'd75;
      default: return 7'd25;
    endcase
  endfunction
endpackage

// File: rtl/frac_thresh.sv
module frac_thresh #(
  parameter int LEN_W = 16
) (
  input  logic [LEN_W-1:0] len_i,
  input  logic [6:0]       pct_i,
  output logic [LEN_W-1:0] thr_o
);
  localparam int PW = LEN_W + 7;

  logic [PW-1:0] prod;
  logic [PW-1:0] quot;

  always_comb begin
    prod  = PW'(len_i) * PW'(pct_i);
    quot  = prod / PW'(100);
    thr_o = quot[LEN_W-1:0];
  end

  // pct never exceeds 100, so the mark stays inside the interval (R3, R6)
  always_comb begin
    if (!$isunknown({len_i, pct_i}))
      p_thr_in_range_r3: assert (thr_o <= len_i);
  end
endmodule

// File: rtl/interval_cnt.sv
module interval_cnt #(
  parameter int LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sof_i,
  output logic [LEN_W-1:0] cnt_o,
  output logic             run_o
);
  localparam logic [LEN_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      run_o <= 1'b0;
    end else if (sof_i) begin
      cnt_o <= '0;
      run_o <= 1'b1;
    end else if (run_o && cnt_o != CNT_MAX) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end

  p_sof_restart_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |=> (cnt_o == '0 && run_o));

  p_cnt_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sof_i && run_o && cnt_o != CNT_MAX) |=> cnt_o == $past(cnt_o) + 1'b1);
endmodule

// File: rtl/periodic_window_sched.sv
module periodic_window_sched #(
  parameter int LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sof_i,
  input  logic [LEN_W-1:0] frame_len_i,
  input  logic [1:0]       int_pt_i,
  input  logic [1:0]       win_sel_i,
  input  logic             per_active_i,
  output logic             eopf_irq_o,
  output logic             per_grant_o
);
  import pws_pkg::*;

  localparam int N_MARK = 2;  // 0: interrupt point, 1: window end

  logic [LEN_W-1:0] len_q;
  logic [1:0]       ipt_q, win_q;
  logic             fired_q;
  logic [LEN_W-1:0] cnt;
  logic             run;
  logic [6:0]       pct   [N_MARK];
  logic [LEN_W-1:0] thr   [N_MARK];

  // configuration snapshot per interval
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q <= '0;
      ipt_q <= '0;
      win_q <= '0;
    end else if (sof_i) begin
      len_q <= frame_len_i;
      ipt_q <= int_pt_i;
      win_q <= win_sel_i;
    end
  end

  interval_cnt #(.LEN_W(LEN_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sof_i  (sof_i),
    .cnt_o  (cnt),
    .run_o  (run)
  );

  assign pct[0] = irq_pct(ipt_q);
  assign pct[1] = win_pct(win_q);

  for (genvar g = 0; g < N_MARK; g++) begin : g_mark
    frac_thresh #(.LEN_W(LEN_W)) u_thr (
      .len_i (len_q),
      .pct_i (pct[g]),
      .thr_o (thr[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         fired_q <= 1'b0;
    else if (sof_i)      fired_q <= 1'b0;
    else if (eopf_irq_o) fired_q <= 1'b1;
  end

  assign eopf_irq_o  = run && !fired_q && (cnt == thr[0]);
  assign per_grant_o = run && per_active_i && (cnt < thr[1]);

  p_irq_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eopf_irq_o |=> !eopf_irq_o);

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> (!eopf_irq_o && !per_grant_o));

  p_cfg_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sof_i |=> ($stable(ipt_q) && $stable(win_q)));

  p_len_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sof_i |=> $stable(len_q));

  p_no_grant_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!per_active_i && !sof_i && run) |-> !per_grant_o);
endmodule

// File: tb/sim_periodic_window_sched.sv
`timescale 1ns/1ps
module sim_periodic_window_sched;
  localparam int LEN_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             sof = 1'b0;
  logic [LEN_W-1:0] flen = '0;
  logic [1:0]       ipt = '0;
  logic [1:0]       wsel = '0;
  logic             pact = 1'b0;
  logic             irq, grant;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  periodic_window_sched #(.LEN_W(LEN_W)) u0 (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .sof_i        (sof),
    .frame_len_i  (flen),
    .int_pt_i     (ipt),
    .win_sel_i    (wsel),
    .per_active_i (pact),
    .eopf_irq_o   (irq),
    .per_grant_o  (grant)
  );

  localparam int NV = 8;
  localparam int V_LEN [NV] = '{100, 100, 100, 100, 200, 40, 7, 1000};
  localparam int V_IPT [NV] = '{0,   1,   2,   3,   3,   2,  1, 0};
  localparam int V_WIN [NV] = '{0,   1,   2,   3,   2,   1,  0, 1};
  localparam int V_ACT [NV] = '{1,   1,   1,   1,   1,   0,  1, 1};

  function automatic int ipct(input int c);
    return (c == 0) ? 80 : (c == 1) ? 85 : (c == 2) ? 90 : 95;
  endfunction

  function automatic int wpct(input int c);
    return (c == 1) ? 50 : (c == 2) ? 75 : 25;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge; runs one interval of 'cycles' cycles
  task automatic run_iv(input int len, input int ip, input int ws, input int pa,
                        input int cycles, input bit mid_chg, input string tag);
    int ithr, wthr, irq_n, irq_at, g_bad, g_first_bad;
    ithr = len * ipct(ip) / 100;
    wthr = len * wpct(ws) / 100;
    irq_n = 0; irq_at = -1; g_bad = 0; g_first_bad = -1;
    flen = LEN_W'(len); ipt = 2'(ip); wsel = 2'(ws); pact = pa[0];
    sof = 1'b1;
    @(negedge clk);
    sof = 1'b0;
    for (int t = 0; t < cycles; t++) begin
      if (mid_chg && t == 10) begin
        ipt  = 2'd3;
        wsel = 2'd2;
        flen = LEN_W'(len * 2);
      end
      if (irq) begin
        irq_n++;
        if (irq_at < 0) irq_at = t;
      end
      if (grant != ((pa != 0) && (t < wthr))) begin
        g_bad++;
        if (g_first_bad < 0) g_first_bad = t;
      end
      @(negedge clk);
    end
    if (ithr < cycles) begin
      chk(irq_n == 1, {"R4 pulse count ", tag}, irq_n, 1);
      chk(irq_at == ithr, {"R3 pulse cycle ", tag}, irq_at, ithr);
    end else begin
      chk(irq_n == 0, {"R5 suppressed ", tag}, irq_n, 0);
    end
    if (pa == 0)
      chk(g_bad == 0, {"R8 grant low ", tag}, g_first_bad, -1);
    else if (ws == 3)
      chk(g_bad == 0, {"R7 reserved window ", tag}, g_first_bad, -1);
    else
      chk(g_bad == 0, {"R6 window ", tag}, g_first_bad, -1);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    pact = 1'b1;
    wsel = 2'd2;
    // R1: idle until the first strobe
    for (int i = 0; i < 5; i++) begin
      chk(irq == 1'b0, "R1 irq idle", int'(irq), 0);
      chk(grant == 1'b0, "R1 grant idle", int'(grant), 0);
      @(negedge clk);
    end

    for (int v = 0; v < NV; v++)
      run_iv(V_LEN[v], V_IPT[v], V_WIN[v], V_ACT[v], V_LEN[v], 1'b0, $sformatf("vec%0d", v));

    // R5: strobe arrives before the 80% point
    run_iv(100, 0, 0, 1, 50, 1'b0, "short");
    // R2: after a cut-short interval the count restarts from 0
    run_iv(100, 0, 0, 1, 100, 1'b0, "restart R2");
    // R9, R10: codes and length change at t = 10 but marks hold
    run_iv(100, 0, 0, 1, 100, 1'b0, "pre");
    run_iv(100, 1, 1, 1, 100, 1'b1, "mid-change R9 R10");
    // R9: the new codes take effect on the next strobe
    run_iv(100, 3, 2, 1, 100, 1'b0, "after-change R9");
    // R4: interval longer than programmed length: still one pulse
    run_iv(20, 2, 1, 1, 60, 1'b0, "long R4");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule